// File: doc/BRIEF.md
# Text display row window

This block decides, for each caption row being scanned out, whether that row belongs to the text display window. One 8-bit configuration byte describes the window. Its upper nibble is the number of rows and its lower nibble is the bottom (base) row. The window ends at the base row and reaches upward by the row count. If that would place rows above the top of the screen, the window is moved so that it starts at row 1 and still spans the programmed number of rows.

The scan-out logic presents the current row index, from 1 to 15, each time a row is scanned. The block returns three registered outputs:
- an in-window flag;
- the first row of the resolved window;
- the last row of the resolved window.

A new configuration byte is accepted at any time. It takes effect only at the next change of the row index, so a row is never judged under two settings.

Top module: `txt_row_window`

## Requirements
- R1: After reset the configuration is FFh (15 rows, base row 15). The outputs are first_row = 1, last_row = 15 and in_win = 0.
- R2: The configuration byte carries the row count in bits 7:4 and the base row in bits 3:0. When the count does not exceed the base, the window is rows base-count+1 through base inclusive. For example, 8Ch gives rows 5 to 12.
- R3: When the count exceeds the base, the window is clamped to rows 1 through count. For example, 83h gives rows 1 to 8.
- R4: A count of 0 gives an empty window. In that case in_win is never asserted, and first_row and last_row both report the base row.
- R5: A base row of 0 is treated as base row 1.
- R6: A configuration write changes nothing while the row index holds steady. The written value takes effect on the first clock where the row index differs from its value on the previous clock.
- R7: in_win, first_row and last_row are registered. Each reflects a new row index on the clock edge that samples it, and so is visible one clock after the row index changes.
- R8: Row index 0 is never inside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: count in bits 7:4, base row in bits 3:0 |
| row_idx | input | 4 | Row currently being scanned, 1 to 15 |
| in_win | output | 1 | High when the row sampled last clock is inside the window |
| first_row | output | 4 | Top row of the resolved window |
| last_row | output | 4 | Bottom row of the resolved window |

## Verification
The window calculation is tried with three kinds of byte:
- Unclamped bytes (FFh, 8Ch, 2Fh) probe the rows just inside and just outside both edges. These show that the window is inclusive at both ends and that count and base are not swapped.
- Clamping bytes (83h, 30h) show that a window reaching past the top keeps its full count instead of being truncated.
- Zero-count and zero-base bytes separate the empty-window rule from the rule that promotes base 0 to base 1.

Directed tests cover the rest:
- A write made while the row index holds steady must leave every output unchanged until the row changes.
- Row index 0 must never be reported as inside the window.

// File: rtl/txt_row_window_pkg.sv
package txt_row_window_pkg;
    localparam int ROW_W = 4;
    localparam int CFG_W = 2 * ROW_W;

    typedef logic [ROW_W-1:0] row_t;

    typedef struct packed {
        logic in_win;
        row_t first;
        row_t last;
    } win_out_t;
endpackage

// File: rtl/txt_cfg_hold.sv
module txt_cfg_hold
    import txt_row_window_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  row_t             row_idx,
    output logic [CFG_W-1:0] cfg_eff,
    output logic             row_edge
);
    typedef struct packed {
        logic [CFG_W-1:0] pend;
        logic [CFG_W-1:0] act;
        row_t             row;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        row_edge = (row_idx != st_q.row);
        st_d.row = row_idx;
        if (cfg_we) begin
            st_d.pend = cfg_wdata;
        end
        if (row_edge) begin
            st_d.act = st_q.pend;
        end
        cfg_eff = row_edge ? st_q.pend : st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= RESET_CFG;
            st_q.act  <= RESET_CFG;
            st_q.row  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the pending byte never moves into use unless the row changes
    a_r6_pend_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx == st_q.row) |=> $stable(st_q.act));
endmodule

// File: rtl/txt_win_resolve.sv
module txt_win_resolve
    import txt_row_window_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  row_t             row,
    output win_out_t         res
);
    row_t cnt;
    row_t base;

    always_comb begin
        cnt  = cfg[CFG_W-1:ROW_W];
        base = cfg[ROW_W-1:0];
        if (base == '0) begin
            base = row_t'(1);
        end
        if (cnt == '0) begin
            res.first = base;
            res.last  = base;
        end else if (cnt > base) begin
            res.first = row_t'(1);
            res.last  = cnt;
        end else begin
            res.first = base - cnt + row_t'(1);
            res.last  = base;
        end
        res.in_win = (cnt != '0) && (row != '0) &&
                     (row >= res.first) && (row <= res.last);
    end
endmodule

// File: rtl/txt_row_window.sv
module txt_row_window
    import txt_row_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic [3:0] row_idx,
    output logic       in_win,
    output logic [3:0] first_row,
    output logic [3:0] last_row
);
    localparam logic [CFG_W-1:0] RESET_CFG = '1;

    logic [CFG_W-1:0] cfg_eff;
    logic             row_edge;
    win_out_t         res;
    win_out_t         out_d, out_q;

    txt_cfg_hold #(.RESET_CFG(RESET_CFG)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .row_idx   (row_idx),
        .cfg_eff   (cfg_eff),
        .row_edge  (row_edge)
    );

    txt_win_resolve u_resolve (
        .cfg (cfg_eff),
        .row (row_idx),
        .res (res)
    );

    always_comb begin
        out_d = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.in_win <= 1'b0;
            out_q.first  <= row_t'(1);
            out_q.last   <= row_t'(15);
        end else begin
            out_q <= out_d;
        end
    end

    assign in_win    = out_q.in_win;
    assign first_row = out_q.first;
    assign last_row  = out_q.last;

    // R2: the reported window is ordered and never starts at row 0
    a_r2_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        (first_row != 4'd0) && (first_row <= last_row));

    // R7: the flag matches the row sampled one clock earlier
    a_r7_flag_row: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (($past(row_idx) >= first_row) && ($past(row_idx) <= last_row)));

    // R8: row 0 is never in the window
    a_r8_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx == 4'd0) |=> !in_win);

    // R6: a steady row index keeps the reported window steady
    a_r6_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx == $past(row_idx)) |=> ($stable(first_row) && $stable(last_row)));
endmodule

// File: tb/txt_row_window_bench.sv
module txt_row_window_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [3:0] row_idx = 4'd0;
    logic       in_win;
    logic [3:0] first_row;
    logic [3:0] last_row;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    txt_row_window u_txt_row_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .row_idx   (row_idx),
        .in_win    (in_win),
        .first_row (first_row),
        .last_row  (last_row)
    );

    // Vector fields: req[24:21], cfg[20:13], row[12:9], in[8], first[7:4], last[3:0]
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2, 8'hFF, 4'd1,  1'b1, 4'd1,  4'd15},  // R2 top edge of full window
        {4'd2, 8'hFF, 4'd15, 1'b1, 4'd1,  4'd15},  // R2 bottom edge
        {4'd2, 8'h8C, 4'd4,  1'b0, 4'd5,  4'd12},  // R2 just above
        {4'd2, 8'h8C, 4'd5,  1'b1, 4'd5,  4'd12},  // R2 first row
        {4'd2, 8'h8C, 4'd12, 1'b1, 4'd5,  4'd12},  // R2 base row
        {4'd2, 8'h8C, 4'd13, 1'b0, 4'd5,  4'd12},  // R2 just below
        {4'd3, 8'h83, 4'd8,  1'b1, 4'd1,  4'd8},   // R3 clamped keeps count
        {4'd3, 8'h83, 4'd9,  1'b0, 4'd1,  4'd8},   // R3 below clamped window
        {4'd4, 8'h0C, 4'd12, 1'b0, 4'd12, 4'd12},  // R4 empty window
        {4'd5, 8'h30, 4'd1,  1'b1, 4'd1,  4'd3},   // R5 base 0 as 1, clamped
        {4'd5, 8'h30, 4'd4,  1'b0, 4'd1,  4'd3},   // R5
        {4'd2, 8'h11, 4'd1,  1'b1, 4'd1,  4'd1},   // R2 single row
        {4'd3, 8'hF1, 4'd15, 1'b1, 4'd1,  4'd15},  // R3 large clamp
        {4'd2, 8'h2F, 4'd14, 1'b1, 4'd14, 4'd15},  // R2 two rows at bottom
        {4'd2, 8'h2F, 4'd13, 1'b0, 4'd14, 4'd15},  // R2
        {4'd5, 8'h10, 4'd1,  1'b1, 4'd1,  4'd1}    // R5 one row, base 0
    };

    task automatic check(input int req, input logic exp_in,
                         input logic [3:0] exp_first, input logic [3:0] exp_last);
        n_tests++;
        if (in_win !== exp_in || first_row !== exp_first || last_row !== exp_last) begin
            n_fail++;
            $display("FAIL R%0d: in/first/last = %0b/%0d/%0d, expected %0b/%0d/%0d",
                     req, in_win, first_row, last_row, exp_in, exp_first, exp_last);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic go_row(input logic [3:0] r);
        row_idx = r;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 4'd1, 4'd15);  // R1 outputs during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 4'd1, 4'd15);  // R1 after release, row 0
        go_row(4'd9);
        check(1, 1'b1, 4'd1, 4'd15);  // R1 reset config is FFh

        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i][20:13]);
            go_row(4'd0);
            go_row(VEC[i][12:9]);
            check(int'(VEC[i][24:21]), VEC[i][8], VEC[i][7:4], VEC[i][3:0]);
        end

        // R6: a write while the row holds does nothing until the row changes
        write_cfg(8'h8C);
        go_row(4'd0);
        go_row(4'd7);
        check(6, 1'b1, 4'd5, 4'd12);
        write_cfg(8'h30);
        repeat (3) @(negedge clk);
        check(6, 1'b1, 4'd5, 4'd12);
        go_row(4'd8);
        check(6, 1'b0, 4'd1, 4'd3);

        // R7: output follows a row change after exactly one clock
        write_cfg(8'h8C);
        go_row(4'd0);
        go_row(4'd4);
        check(7, 1'b0, 4'd5, 4'd12);
        row_idx = 4'd6;
        #1;
        check(7, 1'b0, 4'd5, 4'd12);  // R7 not yet sampled
        @(negedge clk);
        check(7, 1'b1, 4'd5, 4'd12);

        // R8: row 0 under the full window
        write_cfg(8'hFF);
        go_row(4'd3);
        go_row(4'd0);
        check(8, 1'b0, 4'd1, 4'd15);

        // R4: empty window rejects every row
        write_cfg(8'h05);
        go_row(4'd0);
        for (int r = 1; r < 16; r++) begin
            go_row(r[3:0]);
            check(4, 1'b0, 4'd5, 4'd5);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule